// File: doc/BRIEF.md
# Paged Register Access Bridge

This block gives a host on a flat 16-bit register bus indirect access to a large paged register space. The host sees three registers: a command register, a write-data register and a read-data register. A single command word carries the page number, the register index, a direction bit and a start/busy bit. Writing a command with the start bit set launches exactly one transaction on a downstream paged register port. That port uses a request/acknowledge handshake and has variable latency.

For a write, software first loads the write-data register and then issues the command. For a read, it issues the command, polls the busy bit in the command register until it clears, and then fetches the result from the read-data register. A command written while a transaction is still in flight is dropped, and a sticky error flag records the drop. The transfer engine is a three-state machine:

- `XS_IDLE` goes to `XS_REQ` when a command is accepted.
- `XS_REQ` goes to `XS_RETIRE` when the acknowledge is sampled.
- `XS_RETIRE` goes to `XS_IDLE` unconditionally.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset, `dn_req` and `drop_err` are 0, and the command, write-data and read-data registers all read back 0.
- R2: The host address map is fixed:
  - command register at 0x3F8;
  - read-data register at 0x3FC;
  - write-data register at 0x400.
  
  Any other address reads 0. A host write to the read-data register or to an unmapped address changes nothing.
- R3: A host write to the command register with bit 15 set, while the bridge is idle, raises `dn_req` in the next cycle. The request carries `dn_page` = command bits [6:1], `dn_reg` = command bits [11:7] and `dn_we` = command bit 14. Command bits 13:12 and bit 0 do not affect the request.
- R4: A write transaction presents on `dn_wdata` the write-data register value held when the command was accepted.
- R5: `dn_req` and all request fields stay constant until `dn_ack` is sampled high. `dn_req` is low in the cycle after the acknowledge.
- R6: Command bit 15 reads back as busy. Busy is 1 from the cycle after acceptance until the second clock edge after the acknowledge is sampled, so an acknowledge latency of L cycles gives L+1 busy cycles. Command bits 14:0 read back as the last accepted command word.
- R7: A read transaction loads `dn_rdata` into the read-data register at the acknowledge edge. That value holds until the next read completes. A write transaction leaves it unchanged.
- R8: A command register write while busy is dropped: it changes neither the stored command nor the transaction in flight. It sets `drop_err`, which stays set until reset.
- R9: A command written with bit 15 clear while idle is stored for read-back, and no transaction starts.
- R10: Host writes to the write-data register during a transaction update the register but do not change `dn_wdata` of the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 11 | Host register address (also selects read-back) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read-back data for `host_addr` |
| dn_req | output | 1 | Downstream request |
| dn_page | output | 6 | Downstream page number |
| dn_reg | output | 5 | Downstream register index |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_wdata | output | 16 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 16 | Downstream read data, valid with `dn_ack` |
| drop_err | output | 1 | Sticky flag for a command dropped while busy |

## Verification
The bench builds the bridge with its default parameters: a 6-bit page and a 5-bit register index, 2048 locations in all. Because the space is this small, the bench writes and then reads back every page/register pair through the indirect path. The acknowledge latency is a function of the address and spans every value from 1 to 16 cycles, and the ignored command bits change from one transaction to the next. Directed cases then cover the following:
- exact busy duration;
- a dropped command and write-data traffic during an in-flight write;
- commands without the start bit;
- writes to the read-only and unmapped addresses.

// File: rtl/prb_pkg.sv
package prb_pkg;

    // Host register offsets
    localparam int CMD_OFFSET   = 'h3F8;
    localparam int RDATA_OFFSET = 'h3FC;
    localparam int WDATA_OFFSET = 'h400;

    // Command word field positions
    localparam int GO_BIT   = 15;
    localparam int DIR_BIT  = 14;
    localparam int REG_LSB  = 7;
    localparam int PAGE_LSB = 1;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_REQ    = 2'd1,
        XS_RETIRE = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/prb_host_regs.sv
module prb_host_regs
    import prb_pkg::*;
#(
    parameter int HOST_AW = 11,
    parameter int DW      = 16,
    parameter int PAGE_W  = 6,
    parameter int REG_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    input  logic               busy,
    input  logic [DW-1:0]      rd_hold,
    output logic [DW-1:0]      host_rdata,
    output logic               start,
    output logic [PAGE_W-1:0]  start_page,
    output logic [REG_W-1:0]   start_idx,
    output logic               start_we,
    output logic [DW-1:0]      wdata_q,
    output logic               drop_err
);

    localparam logic [HOST_AW-1:0] A_CMD = HOST_AW'(CMD_OFFSET);
    localparam logic [HOST_AW-1:0] A_RD  = HOST_AW'(RDATA_OFFSET);
    localparam logic [HOST_AW-1:0] A_WD  = HOST_AW'(WDATA_OFFSET);

    logic            hit_cmd;
    logic            hit_wd;
    logic [DW-2:0]   cmd_q;

    assign hit_cmd    = host_wr_en && (host_addr == A_CMD);
    assign hit_wd     = host_wr_en && (host_addr == A_WD);
    assign start      = hit_cmd && host_wdata[GO_BIT] && !busy;
    assign start_page = host_wdata[PAGE_LSB +: PAGE_W];
    assign start_idx  = host_wdata[REG_LSB +: REG_W];
    assign start_we   = host_wdata[DIR_BIT];

    // Command word store: only accepted while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (hit_cmd && !busy) begin
            cmd_q <= host_wdata[DW-2:0];
        end
    end

    // Write-data register: always writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (hit_wd) begin
            wdata_q <= host_wdata;
        end
    end

    // Sticky drop flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_err <= 1'b0;
        end else if (hit_cmd && busy) begin
            drop_err <= 1'b1;
        end
    end

    // Read-back multiplexer
    always_comb begin
        case (host_addr)
            A_CMD:   host_rdata = {busy, cmd_q};
            A_RD:    host_rdata = rd_hold;
            A_WD:    host_rdata = wdata_q;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/prb_xfer_fsm.sv
module prb_xfer_fsm
    import prb_pkg::*;
#(
    parameter int DW     = 16,
    parameter int PAGE_W = 6,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [REG_W-1:0]  start_idx,
    input  logic              start_we,
    input  logic [DW-1:0]     start_wdata,
    input  logic              dn_ack,
    input  logic [DW-1:0]     dn_rdata,
    output logic              dn_req,
    output logic [PAGE_W-1:0] dn_page,
    output logic [REG_W-1:0]  dn_reg,
    output logic              dn_we,
    output logic [DW-1:0]     dn_wdata,
    output logic              busy,
    output logic [DW-1:0]     rd_hold
);

    xfer_state_t state_q;
    xfer_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:   if (start)  state_d = XS_REQ;
            XS_REQ:    if (dn_ack) state_d = XS_RETIRE;
            XS_RETIRE: state_d = XS_IDLE;
            default:   state_d = XS_IDLE;
        endcase
    end

    // Launch snapshot: fields held for the whole request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dn_page  <= '0;
            dn_reg   <= '0;
            dn_we    <= 1'b0;
            dn_wdata <= '0;
        end else if (state_q == XS_IDLE && start) begin
            dn_page  <= start_page;
            dn_reg   <= start_idx;
            dn_we    <= start_we;
            dn_wdata <= start_wdata;
        end
    end

    // Read-data capture at the acknowledge edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hold <= '0;
        end else if (state_q == XS_REQ && dn_ack && !dn_we) begin
            rd_hold <= dn_rdata;
        end
    end

    // Outputs
    always_comb begin
        dn_req = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            XS_IDLE:   busy   = 1'b0;
            XS_REQ:    dn_req = 1'b1;
            XS_RETIRE: dn_req = 1'b0;
            default:   busy   = 1'b0;
        endcase
    end

endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
    import prb_pkg::*;
#(
    parameter int HOST_AW = 11,
    parameter int DW      = 16,
    parameter int PAGE_W  = 6,
    parameter int REG_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic               dn_req,
    output logic [PAGE_W-1:0]  dn_page,
    output logic [REG_W-1:0]   dn_reg,
    output logic               dn_we,
    output logic [DW-1:0]      dn_wdata,
    input  logic               dn_ack,
    input  logic [DW-1:0]      dn_rdata,
    output logic               drop_err
);

    logic              busy;
    logic [DW-1:0]     rd_hold;
    logic              start;
    logic [PAGE_W-1:0] start_page;
    logic [REG_W-1:0]  start_idx;
    logic              start_we;
    logic [DW-1:0]     wdata_q;

    prb_host_regs #(
        .HOST_AW (HOST_AW),
        .DW      (DW),
        .PAGE_W  (PAGE_W),
        .REG_W   (REG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .rd_hold    (rd_hold),
        .host_rdata (host_rdata),
        .start      (start),
        .start_page (start_page),
        .start_idx  (start_idx),
        .start_we   (start_we),
        .wdata_q    (wdata_q),
        .drop_err   (drop_err)
    );

    prb_xfer_fsm #(
        .DW     (DW),
        .PAGE_W (PAGE_W),
        .REG_W  (REG_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_page  (start_page),
        .start_idx   (start_idx),
        .start_we    (start_we),
        .start_wdata (wdata_q),
        .dn_ack      (dn_ack),
        .dn_rdata    (dn_rdata),
        .dn_req      (dn_req),
        .dn_page     (dn_page),
        .dn_reg      (dn_reg),
        .dn_we       (dn_we),
        .dn_wdata    (dn_wdata),
        .busy        (busy),
        .rd_hold     (rd_hold)
    );

endmodule

// File: rtl/prb_checker.sv
module prb_checker
    import prb_pkg::*;
#(
    parameter int HOST_AW = 11,
    parameter int DW      = 16,
    parameter int PAGE_W  = 6,
    parameter int REG_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr_en,
    input logic [HOST_AW-1:0] host_addr,
    input logic [DW-1:0]      host_wdata,
    input logic [DW-1:0]      host_rdata,
    input logic               dn_req,
    input logic [PAGE_W-1:0]  dn_page,
    input logic [REG_W-1:0]   dn_reg,
    input logic               dn_we,
    input logic [DW-1:0]      dn_wdata,
    input logic               dn_ack,
    input logic [DW-1:0]      dn_rdata,
    input logic               drop_err,
    input logic               busy,
    input logic [DW-1:0]      rd_hold
);

    localparam logic [HOST_AW-1:0] A_CMD = HOST_AW'(CMD_OFFSET);

    logic cmd_wr;
    assign cmd_wr = host_wr_en && (host_addr == A_CMD);

    assert_start_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && host_wdata[GO_BIT] && !busy) |=>
            (dn_req && dn_page == $past(host_wdata[PAGE_LSB +: PAGE_W])
                    && dn_reg == $past(host_wdata[REG_LSB +: REG_W])
                    && dn_we == $past(host_wdata[DIR_BIT])));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=>
            (dn_req && $stable(dn_page) && $stable(dn_reg)
                    && $stable(dn_we) && $stable(dn_wdata)));

    assert_req_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack) |=> !dn_req);

    assert_busy_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == A_CMD) |-> (host_rdata[GO_BIT] == busy));

    assert_read_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack && !dn_we) |=> (rd_hold == $past(dn_rdata)));

    assert_write_keeps_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack && dn_we) |=> $stable(rd_hold));

    assert_drop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> drop_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |=> drop_err);

    assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dn_req);

endmodule

bind paged_reg_bridge prb_checker #(
    .HOST_AW (HOST_AW),
    .DW      (DW),
    .PAGE_W  (PAGE_W),
    .REG_W   (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .dn_req     (dn_req),
    .dn_page    (dn_page),
    .dn_reg     (dn_reg),
    .dn_we      (dn_we),
    .dn_wdata   (dn_wdata),
    .dn_ack     (dn_ack),
    .dn_rdata   (dn_rdata),
    .drop_err   (drop_err),
    .busy       (busy),
    .rd_hold    (rd_hold)
);

// File: tb/paged_reg_bridge_tb.sv
`timescale 1ns/1ps
module paged_reg_bridge_tb;

    localparam logic [10:0] CMD_A = 11'h3F8;
    localparam logic [10:0] RD_A  = 11'h3FC;
    localparam logic [10:0] WD_A  = 11'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [10:0] host_addr = CMD_A;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        dn_req;
    logic [5:0]  dn_page;
    logic [4:0]  dn_reg;
    logic        dn_we;
    logic [15:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic [15:0] dn_rdata = '0;
    logic        drop_err;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    logic [5:0]  exp_page;
    logic [4:0]  exp_reg;
    logic        exp_we;
    logic [15:0] exp_wdata;
    logic [15:0] mem [0:2047];

    always #10 clk = ~clk;

    paged_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dn_req(dn_req),
        .dn_page(dn_page), .dn_reg(dn_reg), .dn_we(dn_we), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata), .drop_err(drop_err)
    );

    function automatic int lat_of(input int p, input int r);
        return ((p * 3 + r) % 16) + 1;
    endfunction

    function automatic logic [15:0] data_of(input int p, input int r);
        return 16'((p * 16'h0405) ^ (r * 16'h1111) ^ 16'hA5C3);
    endfunction

    function automatic logic [15:0] cmd_of(input int p, input int r, input bit we, input int junk);
        return 16'h8000 | (16'(we) << 14) | (16'(junk & 3) << 12)
             | (16'(r) << 7) | (16'(p) << 1) | 16'((junk >> 2) & 1);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural downstream register file with address-dependent latency
    initial begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (dn_ack) begin
                dn_ack = 1'b0;
            end else if (dn_req) begin
                cnt++;
                if (cnt >= lat_of(int'(dn_page), int'(dn_reg))) begin
                    cnt = 0;
                    dn_ack = 1'b1;
                    chk("R3 page", 16'(dn_page), 16'(exp_page));
                    chk("R3 reg", 16'(dn_reg), 16'(exp_reg));
                    chk("R3 dir", 16'(dn_we), 16'(exp_we));
                    if (dn_we) begin
                        chk("R4 wdata", dn_wdata, exp_wdata);
                        mem[{dn_page, dn_reg}] = dn_wdata;
                    end else begin
                        dn_rdata = mem[{dn_page, dn_reg}];
                    end
                end
            end
        end
    end

    task automatic host_write(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [10:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_idle();
        host_addr = CMD_A;
        for (int i = 0; i < 100; i++) begin
            #1;
            if (!host_rdata[15]) break;
            @(negedge clk);
        end
    endtask

    task automatic run(input int p, input int r, input bit we, input int junk);
        exp_page = 6'(p);
        exp_reg  = 5'(r);
        exp_we   = we;
        host_write(CMD_A, cmd_of(p, r, we, junk));
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int busy_cycles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 req", 16'(dn_req), 16'h0);
        chk("R1 drop_err", 16'(drop_err), 16'h0);
        host_read(CMD_A, v); chk("R1 cmd", v, 16'h0);
        host_read(RD_A, v);  chk("R1 rdata", v, 16'h0);
        host_read(WD_A, v);  chk("R1 wdata", v, 16'h0);

        // R2 unmapped and read-only addresses
        host_read(11'h3F9, v); chk("R2 unmapped", v, 16'h0);
        host_write(RD_A, 16'hFFFF);
        host_write(11'h123, 16'hFFFF);
        host_read(RD_A, v); chk("R2 rdata ro", v, 16'h0);
        host_read(WD_A, v); chk("R2 wdata", v, 16'h0);
        host_read(CMD_A, v); chk("R2 cmd", v, 16'h0);

        // R9 command without start bit
        host_write(CMD_A, 16'h5A5A);
        for (int i = 0; i < 5; i++) begin
            #1 chk("R9 no req", 16'(dn_req), 16'h0);
            @(negedge clk);
        end
        host_read(CMD_A, v); chk("R9 stored", v, 16'h5A5A);

        // R6 busy duration: page 2 reg 1, latency 8
        exp_page = 6'd2; exp_reg = 5'd1; exp_we = 1'b0;
        host_write(CMD_A, cmd_of(2, 1, 1'b0, 0));
        host_addr = CMD_A;
        #1 chk("R3 req next cycle", 16'(dn_req), 16'h1);
        busy_cycles = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (!host_rdata[15]) break;
            busy_cycles++;
            @(negedge clk);
        end
        chk("R6 busy cycles", 16'(busy_cycles), 16'(lat_of(2, 1) + 1));
        host_read(CMD_A, v); chk("R6 cmd readback", v, cmd_of(2, 1, 1'b0, 0) & 16'h7FFF);

        // Sweep: write every location, then read every location back
        for (int p = 0; p < 64; p++) begin
            for (int r = 0; r < 32; r++) begin
                exp_wdata = data_of(p, r);
                host_write(WD_A, exp_wdata);
                run(p, r, 1'b1, p + r);
            end
        end
        host_read(RD_A, v); chk("R7 writes keep rdata", v, 16'h0);
        for (int p = 0; p < 64; p++) begin
            for (int r = 0; r < 32; r++) begin
                run(p, r, 1'b0, p ^ r);
                host_read(RD_A, v);
                chk("R7 read value", v, data_of(p, r));
            end
        end

        // R8 and R10: write to page 5 reg 0 (latency 16), disturbed in flight
        exp_wdata = 16'h1234;
        host_write(WD_A, 16'h1234);
        exp_page = 6'd5; exp_reg = 5'd0; exp_we = 1'b1;
        host_write(CMD_A, cmd_of(5, 0, 1'b1, 0));
        host_write(WD_A, 16'hBEEF);
        host_write(CMD_A, cmd_of(9, 3, 1'b0, 0));
        #1 chk("R8 drop flag", 16'(drop_err), 16'h1);
        host_read(CMD_A, v); chk("R8 cmd unchanged", v, 16'h8000 | (cmd_of(5, 0, 1'b1, 0) & 16'h7FFF));
        wait_idle();
        host_read(WD_A, v); chk("R10 wdata reg", v, 16'hBEEF);
        host_read(RD_A, v); chk("R7 rdata after write", v, data_of(63, 31));
        run(5, 0, 1'b0, 0);
        host_read(RD_A, v); chk("R10 snapshot stored", v, 16'h1234);
        chk("R8 sticky", 16'(drop_err), 16'h1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule